// File: doc/BRIEF.md
# Nested Vectored Interrupt Dispatcher

This block decides, cycle by cycle, whether a single-cycle processor core should leave its current instruction stream and enter an interrupt handler. For each of `NVEC` vectors it keeps three control-register entries: a handler entry holding the handler address divided by four, a configuration entry holding priority, enable and pending bits, and a timestamp captured from a free-running cycle counter. Peripherals raise pending requests on `pend_req`. Software reads and writes the entries through a control-register port.

The controller keeps the running priority level, plus a small stack of preempted levels and return PCs. When a pending, enabled vector outranks the running level and the global enable is set, the controller redirects the core's next fetch to the handler in that same cycle. It also tells the core to load its link register with an all-ones value. The handler is then an ordinary function. Its final jump to the all-ones link value is recognised as an interrupt return. The controller then resumes the preempted code, or chains straight into the next eligible handler.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the running level is 0, the global enable is clear, no redirect or link write is signalled, and every entry reads as zero.
- R2: Handler entry i is at address 0xB00+i and reads back the full written word. Configuration entry i is at 0xB20+i, with bit 0 pending, bit 1 enable and bits 3:2 priority. Timestamp i is at 0xB40+i. Addresses past the last implemented vector read zero.
- R3: The global enable is bit 3 of address 0x300, and the other bits read as zero. While it is clear, no dispatch is signalled.
- R4: When a vector is taken, `redirect` and `link_we` go high in that same cycle and `redirect_pc` equals the handler entry shifted left by 2. `link_data` is 0xFFFFFFFF. After the clock edge, the running level equals the vector's priority and its pending bit is clear.
- R5: Arbitration picks the highest priority among pending, enabled vectors whose priority is strictly above the running level. Ties go to the lowest index. Priority 0 is never taken.
- R6: A handler is preempted only by a vector of strictly higher priority. At that point the current level and `next_pc` are pushed.
- R7: A jump to 0xFFFFFFFF (`jmp_valid` high, `jmp_target` all ones) while the stack is non-empty redirects to the saved PC and restores the saved level. When the stack is empty, such a jump is ignored.
- R8: If a vector outranks the restored level at a return, its handler is entered directly in that cycle. The original saved PC is then used by the later return.
- R9: A `pend_req` pulse sets the pending bit, even when the vector is disabled. It is dispatched as soon as the enable is written. A configuration write sets pending when bit 0 is 1 and leaves it unchanged when bit 0 is 0.
- R10: On a 0-to-1 change of a pending bit, the timestamp takes the counter value of that cycle. The counter is 0 in the first cycle after reset and counts up by one per cycle. The timestamp is not changed while the bit stays set.
- R11: The preemption stack holds `NPRIO` entries and never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Control-register write strobe |
| csr_addr | input | 12 | Control-register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data (combinational) |
| pend_req | input | NVEC | Peripheral pending requests |
| next_pc | input | 32 | PC the core would fetch next |
| jmp_valid | input | 1 | Core executes an indirect jump |
| jmp_target | input | 32 | Target of that jump |
| redirect | output | 1 | Override the next fetch |
| redirect_pc | output | 32 | PC used when redirect is high |
| link_we | output | 1 | Load link register (handler entry) |
| link_data | output | 32 | Value for the link register |
| run_level | output | clog2(NPRIO) | Current running priority |

## Verification
Two functions can fall in the same cycle: an interrupt return and a new dispatch. The bench provokes this by pending an equal-priority vector while a handler runs, so the vector must wait. It then returns from that handler to a lower level. In that cycle the output must show the waiting handler's PC with `link_we` high, and not the saved PC. Two further returns then check that the original saved PC was kept and is handed out at the final return.

// File: rtl/irq_nest_pkg.sv
// Shared constants for the nested interrupt dispatcher: address windows,
// the global-enable location and the return marker. Assumes 32-bit words.
package irq_nest_pkg;
    localparam int XLEN = 32;
    typedef logic [XLEN-1:0] word_t;

    localparam logic [11:0] GIE_ADDR = 12'h300;
    localparam int          GIE_BIT  = 3;
    // Upper seven address bits select a 32-entry window
    localparam logic [6:0]  WIN_TAB  = 7'h58;   // 0xB00
    localparam logic [6:0]  WIN_CFG  = 7'h59;   // 0xB20
    localparam logic [6:0]  WIN_TS   = 7'h5A;   // 0xB40
    localparam word_t       RET_MARK = 32'hFFFF_FFFF;
endpackage

// File: rtl/irq_vec_bank.sv
// Per-vector storage: handler entry, priority/enable, pending bit and
// captured timestamp. Assumes at most one write target per cycle and that
// clr_idx is a valid vector when clr_en is high.
module irq_vec_bank
    import irq_nest_pkg::*;
#(
    parameter int NVEC   = 8,
    parameter int PRIO_W = 2,
    parameter int TS_W   = 32,
    localparam int IDX_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tab_we,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             wr_idx,
    input  word_t                        wdata,
    input  logic [NVEC-1:0]              pend_req,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_idx,
    input  logic [TS_W-1:0]              now,
    output word_t [NVEC-1:0]             tab,
    output logic  [NVEC-1:0][PRIO_W-1:0] prio,
    output logic  [NVEC-1:0]             en,
    output logic  [NVEC-1:0]             pend,
    output logic  [NVEC-1:0][TS_W-1:0]   ts
);
    for (genvar g = 0; g < NVEC; g++) begin : g_vec
        logic hit_w;
        logic pend_nxt;

        // Next pending value: taken clears, write-one and requests set
        always_comb begin
            hit_w    = (wr_idx == IDX_W'(g));
            pend_nxt = (pend[g] & ~(clr_en && clr_idx == IDX_W'(g)))
                     | (cfg_we && hit_w && wdata[0])
                     | pend_req[g];
        end

        // Vector state registers and timestamp capture on pending rise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tab[g]  <= '0;
                prio[g] <= '0;
                en[g]   <= 1'b0;
                pend[g] <= 1'b0;
                ts[g]   <= '0;
            end else begin
                if (tab_we && hit_w) tab[g] <= wdata;
                if (cfg_we && hit_w) begin
                    prio[g] <= wdata[PRIO_W+1:2];
                    en[g]   <= wdata[1];
                end
                pend[g] <= pend_nxt;
                if (!pend[g] && pend_nxt) ts[g] <= now;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Combinational selection of the vector to take: highest priority among
// pending, enabled vectors strictly above the reference level; ties go to
// the lowest index.
module irq_arbiter #(
    parameter int NVEC   = 8,
    parameter int PRIO_W = 2,
    localparam int IDX_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic [NVEC-1:0]             pend,
    input  logic [NVEC-1:0]             en,
    input  logic [NVEC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]           level,
    output logic                        hit,
    output logic [IDX_W-1:0]            sel,
    output logic [PRIO_W-1:0]           best
);
    // Scan downwards so an equal priority at a lower index replaces the pick
    always_comb begin
        hit  = 1'b0;
        sel  = '0;
        best = '0;
        for (int i = NVEC - 1; i >= 0; i--) begin
            if (pend[i] && en[i] && (prio[i] > level) && (!hit || prio[i] >= best)) begin
                hit  = 1'b1;
                best = prio[i];
                sel  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
// Preemption stack of (level, return PC) pairs. Assumes push and pop are
// never both high; push is ignored when full, pop when empty.
module irq_level_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int PRIO_W = 2,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_lvl,
    input  word_t             push_pc,
    output logic [PRIO_W-1:0] top_lvl,
    output word_t             top_pc,
    output logic [DW-1:0]     depth
);
    logic  [DEPTH-1:0][PRIO_W-1:0] lvl_q;
    word_t [DEPTH-1:0]             pc_q;
    logic  [PW-1:0]                top_idx;
    logic  [PW-1:0]                wr_idx;

    // Index of the newest entry and of the next free slot
    always_comb begin
        top_idx = PW'(depth - DW'(1));
        wr_idx  = PW'(depth);
        top_lvl = lvl_q[top_idx];
        top_pc  = pc_q[top_idx];
    end

    // Entry storage and stack pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            pc_q  <= '0;
            depth <= '0;
        end else if (push && depth < DW'(DEPTH)) begin
            lvl_q[wr_idx] <= push_lvl;
            pc_q[wr_idx]  <= push_pc;
            depth         <= depth + DW'(1);
        end else if (pop && depth != '0) begin
            depth <= depth - DW'(1);
        end
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
// Top of the nested vectored interrupt dispatcher. Decodes control-register
// accesses, keeps the global enable, running level and cycle counter, and
// produces same-cycle redirects for dispatch, return and tail-chaining.
// Assumes the core applies redirect_pc to its next fetch when redirect is
// high and writes link_data into its link register when link_we is high.
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NVEC  = 8,
    parameter int NPRIO = 4,
    parameter int TS_W  = 32,
    localparam int PRIO_W = (NPRIO > 1) ? $clog2(NPRIO) : 1,
    localparam int IDX_W  = (NVEC > 1) ? $clog2(NVEC) : 1,
    localparam int DW     = $clog2(NPRIO + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [11:0]       csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic [NVEC-1:0]   pend_req,
    input  logic [31:0]       next_pc,
    input  logic              jmp_valid,
    input  logic [31:0]       jmp_target,
    output logic              redirect,
    output logic [31:0]       redirect_pc,
    output logic              link_we,
    output logic [31:0]       link_data,
    output logic [PRIO_W-1:0] run_level
);
    logic                        gie_q;
    logic [TS_W-1:0]             now;
    logic [6:0]                  win;
    logic                        in_rng;
    logic [IDX_W-1:0]            vidx;
    logic                        tab_we, cfg_we;
    word_t [NVEC-1:0]            tab;
    logic  [NVEC-1:0][PRIO_W-1:0] prio;
    logic  [NVEC-1:0]            en;
    logic  [NVEC-1:0]            pend;
    logic  [NVEC-1:0][TS_W-1:0]  ts;
    logic                        hit;
    logic [IDX_W-1:0]            sel;
    logic [PRIO_W-1:0]           best;
    logic [PRIO_W-1:0]           top_lvl;
    word_t                       top_pc;
    logic [DW-1:0]               depth;
    logic                        ret, take;
    logic [PRIO_W-1:0]           ref_lvl;

    // Address decode for the three vector windows
    always_comb begin
        win    = csr_addr[11:5];
        in_rng = (32'(csr_addr[4:0]) < NVEC);
        vidx   = IDX_W'(csr_addr[4:0]);
        tab_we = csr_we && in_rng && (win == WIN_TAB);
        cfg_we = csr_we && in_rng && (win == WIN_CFG);
    end

    // Return detection, reference level and dispatch decision
    always_comb begin
        ret         = jmp_valid && (jmp_target == RET_MARK) && (depth != '0);
        ref_lvl     = ret ? top_lvl : run_level;
        take        = gie_q && hit;
        redirect    = take || ret;
        redirect_pc = take ? {tab[sel][XLEN-3:0], 2'b00} : top_pc;
        link_we     = take;
        link_data   = RET_MARK;
    end

    // Control-register read mux; unimplemented addresses read zero
    always_comb begin
        csr_rdata = '0;
        if (csr_addr == GIE_ADDR) begin
            csr_rdata[GIE_BIT] = gie_q;
        end else if (in_rng) begin
            unique case (win)
                WIN_TAB: csr_rdata = tab[vidx];
                WIN_CFG: csr_rdata = 32'({prio[vidx], en[vidx], pend[vidx]});
                WIN_TS:  csr_rdata = 32'(ts[vidx]);
                default: csr_rdata = '0;
            endcase
        end
    end

    // Global enable, running level and monotonic cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q     <= 1'b0;
            run_level <= '0;
            now       <= '0;
        end else begin
            now <= now + TS_W'(1);
            if (csr_we && csr_addr == GIE_ADDR) gie_q <= csr_wdata[GIE_BIT];
            if (take)     run_level <= best;
            else if (ret) run_level <= top_lvl;
        end
    end

    irq_vec_bank #(.NVEC(NVEC), .PRIO_W(PRIO_W), .TS_W(TS_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .tab_we(tab_we), .cfg_we(cfg_we), .wr_idx(vidx), .wdata(csr_wdata),
        .pend_req(pend_req), .clr_en(take), .clr_idx(sel), .now(now),
        .tab(tab), .prio(prio), .en(en), .pend(pend), .ts(ts)
    );

    irq_arbiter #(.NVEC(NVEC), .PRIO_W(PRIO_W)) u_arb (
        .pend(pend), .en(en), .prio(prio), .level(ref_lvl),
        .hit(hit), .sel(sel), .best(best)
    );

    // A tail-chain leaves the stack untouched: the saved PC stays on top
    irq_level_stack #(.DEPTH(NPRIO), .PRIO_W(PRIO_W)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(take && !ret), .pop(ret && !take),
        .push_lvl(run_level), .push_pc(next_pc),
        .top_lvl(top_lvl), .top_pc(top_pc), .depth(depth)
    );
endmodule

// File: rtl/irq_nest_chk.sv
// Property checker for irq_nest_ctrl, attached by bind below.
module irq_nest_chk #(
    parameter int NVEC  = 8,
    parameter int NPRIO = 4,
    parameter int TS_W  = 32,
    localparam int PRIO_W = (NPRIO > 1) ? $clog2(NPRIO) : 1,
    localparam int IDX_W  = (NVEC > 1) ? $clog2(NVEC) : 1,
    localparam int DW     = $clog2(NPRIO + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      csr_we,
    input logic [NVEC-1:0]           pend_req,
    input logic                      gie_q,
    input logic                      take,
    input logic                      ret,
    input logic [IDX_W-1:0]          sel,
    input logic [PRIO_W-1:0]         top_lvl,
    input logic [DW-1:0]             depth,
    input logic [NVEC-1:0]           pend,
    input logic [NVEC-1:0][TS_W-1:0] ts,
    input logic                      redirect,
    input logic                      link_we,
    input logic [PRIO_W-1:0]         run_level
);
    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(NPRIO));

    // R3
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> !link_we);

    // R4
    entry_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> redirect);

    // R6
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_level > $past(run_level)) |-> $past(take));

    // R7
    resume_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !take) |=> (run_level == $past(top_lvl)));

    for (genvar g = 0; g < NVEC; g++) begin : g_chk
        // R4
        pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (take && sel == IDX_W'(g) && !pend_req[g] && !csr_we) |=> !pend[g]);

        // R10
        ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(pend[g]) && pend[g]) |-> (ts[g] == $past(ts[g])));
    end
endmodule

bind irq_nest_ctrl irq_nest_chk #(.NVEC(NVEC), .NPRIO(NPRIO), .TS_W(TS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .pend_req(pend_req),
    .gie_q(gie_q), .take(take), .ret(ret), .sel(sel), .top_lvl(top_lvl),
    .depth(depth), .pend(pend), .ts(ts), .redirect(redirect),
    .link_we(link_we), .run_level(run_level)
);

// File: tb/irq_nest_ctrl_bench.sv
// Self-checking bench: table-driven arbitration rows, then directed tests.
module irq_nest_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int NROWS = 6;

    // Row: {nibble per vector (prio<<2|en<<1|pend), expect take, expect idx}
    typedef struct packed {
        logic [31:0] cfg;
        logic        exp_take;
        logic [2:0]  exp_idx;
        logic [1:0]  exp_lvl;
    } row_t;

    localparam row_t ROWS [NROWS] = '{
        '{32'h0000_0B00, 1'b1, 3'd2, 2'd2},
        '{32'h00F0_0070, 1'b1, 3'd5, 2'd3},
        '{32'h0B00_B000, 1'b1, 3'd3, 2'd2},
        '{32'h0000_0003, 1'b0, 3'd0, 2'd0},
        '{32'hE00D_0000, 1'b0, 3'd0, 2'd0},
        '{32'hF000_00F7, 1'b1, 3'd1, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [NVEC-1:0] pend_req = '0;
    logic [31:0] next_pc = '0;
    logic        jmp_valid = 1'b0;
    logic [31:0] jmp_target = 32'hFFFF_FFFF;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic        link_we;
    logic [31:0] link_data;
    logic [1:0]  run_level;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] cyc = '0;
    logic [31:0] k1, k2;

    irq_nest_ctrl u_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .pend_req(pend_req),
        .next_pc(next_pc), .jmp_valid(jmp_valid), .jmp_target(jmp_target),
        .redirect(redirect), .redirect_pc(redirect_pc), .link_we(link_we),
        .link_data(link_data), .run_level(run_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side cycle count per R10: 0 in first cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 32'd1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        step();
        rst_n = 1'b0; csr_we = 1'b0; pend_req = '0; jmp_valid = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic [31:0] at);
        step();
        csr_we = 1'b1; csr_addr = a; csr_wdata = d; at = cyc;
        step();
        csr_we = 1'b0;
        #1;
    endtask

    task automatic wrq(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] unused_at;
        wr(a, d, unused_at);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        csr_addr = a;
        #1;
        check(req, csr_rdata, exp);
    endtask

    task automatic pulse(input logic [NVEC-1:0] m, output logic [31:0] at);
        step();
        pend_req = m; at = cyc;
        step();
        pend_req = '0;
        #1;
    endtask

    task automatic init_tabs();
        for (int i = 0; i < NVEC; i++) wrq(12'hB00 + 12'(i), 32'h100 + 32'(i));
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        check("R1 redirect", 32'(redirect), 0);
        check("R1 link_we", 32'(link_we), 0);
        check("R1 level", 32'(run_level), 0);
        rd_chk("R1 cfg", 12'hB23, 0);
        rd_chk("R1 gie", 12'h300, 0);
        rd_chk("R1 tab", 12'hB05, 0);

        // R2: register map and out-of-range reads
        wrq(12'hB03, 32'hDEAD_BEEF);
        rd_chk("R2 tab readback", 12'hB03, 32'hDEAD_BEEF);
        wrq(12'hB23, 32'h0000_000E);
        rd_chk("R2 cfg readback", 12'hB23, 32'hE);
        wrq(12'hB08, 32'h1234_5678);
        rd_chk("R2 tab out of range", 12'hB08, 0);
        rd_chk("R2 cfg out of range", 12'hB28, 0);
        rd_chk("R2 ts out of range", 12'hB48, 0);

        // R5: table of arbitration rows, one loop
        for (int r = 0; r < NROWS; r++) begin
            do_reset();
            init_tabs();
            for (int v = 0; v < NVEC; v++)
                wrq(12'hB20 + 12'(v), 32'(ROWS[r].cfg[v*4 +: 4]));
            check("R5 no dispatch before gie", 32'(redirect), 0);
            wrq(12'h300, 32'h8);
            check("R5 take", 32'(redirect), 32'(ROWS[r].exp_take));
            if (ROWS[r].exp_take)
                check("R5 handler pc", redirect_pc, (32'h100 + 32'(ROWS[r].exp_idx)) << 2);
            step(); #1;
            check("R5 level after", 32'(run_level), 32'(ROWS[r].exp_lvl));
        end

        // R3: global enable gating
        do_reset();
        init_tabs();
        wrq(12'hB23, 32'hF);
        check("R3 gie clear blocks", 32'(redirect), 0);
        wrq(12'h300, 32'hFFFF_FFF7);
        check("R3 bit3 clear blocks", 32'(redirect), 0);
        rd_chk("R3 gie read zero", 12'h300, 0);
        wrq(12'h300, 32'h8);
        check("R3 gie set dispatches", 32'(redirect), 1);
        check("R3 pc", redirect_pc, 32'h40C);
        rd_chk("R3 gie read", 12'h300, 32'h8);

        // R4 R6 R7 R8: nesting, return and tail-chaining
        do_reset();
        init_tabs();
        wrq(12'h300, 32'h8);
        wrq(12'hB22, 32'h6);
        wrq(12'hB25, 32'hA);
        wrq(12'hB21, 32'h6);
        next_pc = 32'h1000;
        pulse(8'h04, k1);
        check("R4 redirect", 32'(redirect), 1);
        check("R4 link_we", 32'(link_we), 1);
        check("R4 link_data", link_data, 32'hFFFF_FFFF);
        check("R4 pc", redirect_pc, 32'h408);
        rd_chk("R10 ts capture", 12'hB42, k1);
        step(); #1;
        check("R4 level", 32'(run_level), 1);
        rd_chk("R4 pend cleared", 12'hB22, 32'h6);
        next_pc = 32'h2000;
        pulse(8'h02, k2);
        check("R6 equal prio waits", 32'(redirect), 0);
        pulse(8'h20, k2);
        check("R6 preempt", 32'(redirect), 1);
        check("R6 preempt pc", redirect_pc, 32'h414);
        step(); #1;
        check("R6 level", 32'(run_level), 2);
        next_pc = 32'h3000;
        jmp_valid = 1'b1; #1;
        check("R7 resume redirect", 32'(redirect), 1);
        check("R7 resume pc", redirect_pc, 32'h2000);
        check("R7 no link write", 32'(link_we), 0);
        step(); jmp_valid = 1'b0; #1;
        check("R7 level restored", 32'(run_level), 1);
        jmp_valid = 1'b1; #1;
        check("R8 tail-chain pc", redirect_pc, 32'h404);
        check("R8 tail-chain link", 32'(link_we), 1);
        step(); jmp_valid = 1'b0; #1;
        check("R8 level", 32'(run_level), 1);
        jmp_valid = 1'b1; #1;
        check("R8 saved pc kept", redirect_pc, 32'h1000);
        step(); jmp_valid = 1'b0; #1;
        check("R8 back to thread", 32'(run_level), 0);
        jmp_valid = 1'b1; #1;
        check("R7 empty ignored", 32'(redirect), 0);
        step(); jmp_valid = 1'b0; #1;
        check("R7 level stays", 32'(run_level), 0);

        // R9 R10: request before enable, timestamp hold and recapture
        do_reset();
        init_tabs();
        wrq(12'h300, 32'h8);
        pulse(8'h01, k1);
        check("R9 disabled waits", 32'(redirect), 0);
        rd_chk("R9 pend set", 12'hB20, 32'h1);
        rd_chk("R10 ts", 12'hB40, k1);
        repeat (3) step();
        pulse(8'h01, k2);
        rd_chk("R10 ts held", 12'hB40, k1);
        wrq(12'hB20, 32'hE);
        check("R9 dispatch on enable", 32'(redirect), 1);
        check("R9 pc", redirect_pc, 32'h400);
        step(); #1;
        check("R9 level", 32'(run_level), 3);
        wr(12'hB20, 32'hF, k2);
        check("R9 equal no dispatch", 32'(redirect), 0);
        rd_chk("R9 write-one sets pend", 12'hB20, 32'hF);
        rd_chk("R10 recapture", 12'hB40, k2);

        finish_up();
    end
endmodule